// File: doc/BRIEF.md
# Posted-Write Register Bridge to a Power-Management Slave

This block connects a host register bus to the register file of a power-management companion chip. Host writes that land in a 4 KiB slave window are posted. They are queued in a small write queue and sent downstream one at a time, so the host never waits for the slow slave. Local control registers hold a bitmap of enables for the hardware request channels and one configuration word for each hardware channel.

Reads of slave registers are indirect. The host writes the slave address into a command register, and the bridge raises a busy flag at once. The read is sent downstream after every write posted before it has completed. When the answer returns, the result register holds the 16-bit data and also echoes the 12-bit slave offset, so software can confirm which register answered.

The downstream side is a valid/ready request port. The bridge raises `dn_valid` with `dn_we`, `dn_addr` and `dn_wdata`, and holds all of them unchanged until the slave returns `dn_ready` in the same cycle. That cycle completes the transfer. For a read, `dn_rdata` is taken in that cycle. After each transfer `dn_valid` stays low for at least one cycle. The slave may hold `dn_ready` low for as long as it likes, and this back-pressure fills the write queue.

Top module: `pmic_bridge`

## Requirements
- R1: After reset, the queue status register (0x30) reads 0x0000_0400 (empty set, full and overflow clear). The read result register (0x2c) reads 0. `dn_valid` is low and `chan_en` is all zero.
- R2: A host write to 0x8000..0x8FFF produces exactly one downstream write. Its `dn_addr` is host_addr[11:0] and its `dn_wdata` is host_wdata[15:0]. Downstream writes appear in the order the host posted them.
- R3: Only one request is outstanding at a time. While `dn_valid` is high and `dn_ready` is low, `dn_valid`, `dn_we`, `dn_addr` and `dn_wdata` keep their values.
- R4: The write queue holds FIFO_DEPTH (8) entries, plus one write in flight on the port. Status bit 11 reads 1 exactly when the queue holds FIFO_DEPTH entries. Status bit 10 reads 1 when the queue is empty and no write is in flight.
- R5: A window write that arrives while the queue is full is dropped and sets the sticky overflow flag, status bit 12. Writing 0x30 with bit 12 set clears the flag.
- R6: Writing the read command register (0x28) starts a read of slave offset host_wdata[11:0]. Result bit 31 (busy) reads 1 from the next cycle. Busy clears when the downstream read completes. The result then holds the returned data in bits 15:0, the offset in bits 27:16, and zeros in bits 30:28.
- R7: A read is not sent downstream until every window write posted before the command has completed. The result therefore reflects those writes.
- R8: A read command written while busy is set is ignored. The read in progress and its echoed offset are unchanged.
- R9: Enable register 0x40 holds the enables of channels 0..31 at bit index equal to the channel number. Register 0x20c holds channels 32..49 at bit index (channel − 32), and its bits 31:18 read 0. Channels 0 and 1 are software channels: their bits read 0 and ignore writes. `chan_en` outputs the 50-bit map.
- R10: Each hardware channel n (2..49) has a 32-bit configuration word at 0x44 + (n − 2)·4, which reads back the value last written.
- R11: Host writes outside the slave window never produce a downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, combinational while host_sel and !host_we |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream acknowledge; the transfer completes when valid and ready are both high |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 12 | Slave register offset |
| dn_wdata | output | 16 | Slave write data |
| dn_rdata | input | 16 | Slave read data, sampled on a read handshake |
| chan_en | output | 50 | Channel enable bitmap |

## Verification
The assertions check the following on every cycle:
- the downstream request stays stable under back-pressure;
- a read request is only issued after the write queue was empty;
- busy rises after a command and falls only on a read handshake;
- a command written while busy leaves the read address alone;
- overflow is sticky;
- the queue is never full and empty at once.

Only the bench's scenarios can show the end-to-end results, which depend on a slave model:
- the order and content of writes arriving at the slave;
- the exact fill point of the queue and the dropped write;
- the data and echoed offset in the read result;
- the channel register map, including its read-only bits.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;
  localparam int HOST_AW = 16;
  localparam int HOST_DW = 32;
  localparam int SLV_AW  = 12;
  localparam int SLV_DW  = 16;

  localparam logic [HOST_AW-1:0] A_RD_CMD   = 16'h0028;
  localparam logic [HOST_AW-1:0] A_RD_RES   = 16'h002c;
  localparam logic [HOST_AW-1:0] A_Q_STAT   = 16'h0030;
  localparam logic [HOST_AW-1:0] A_EN_LO    = 16'h0040;
  localparam logic [HOST_AW-1:0] A_CFG_BASE = 16'h0044;
  localparam logic [HOST_AW-1:0] A_EN_HI    = 16'h020c;
  localparam logic [3:0]         WIN_NIBBLE = 4'h8;

  localparam int ST_EMPTY = 10;
  localparam int ST_FULL  = 11;
  localparam int ST_OVF   = 12;
  localparam int RES_BUSY = 31;

  typedef struct packed {
    logic [SLV_AW-1:0] addr;
    logic [SLV_DW-1:0] data;
  } wr_ent_t;
endpackage

// File: rtl/pmic_bridge_wq.sv
module pmic_bridge_wq
  import pmic_bridge_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  wr_ent_t din,
  input  logic    pop,
  output wr_ent_t dout,
  output logic    full,
  output logic    empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wr_ent_t        mem_q [DEPTH];
  logic [PW-1:0]  wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic           do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pmic_bridge_seq.sv
module pmic_bridge_seq
  import pmic_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  wr_ent_t           q_head,
  output logic              q_pop,
  input  logic              rd_pend,
  input  logic [SLV_AW-1:0] rd_addr,
  output logic              rd_take,
  output logic              rd_done,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_we,
  output logic [SLV_AW-1:0] dn_addr,
  output logic [SLV_DW-1:0] dn_wdata
);
  logic              v_q, we_q;
  logic [SLV_AW-1:0] a_q;
  logic [SLV_DW-1:0] d_q;

  // posted writes always win over a pending read: ordering rule
  assign q_pop   = !v_q && !q_empty;
  assign rd_take = !v_q && q_empty && rd_pend;
  assign rd_done = v_q && dn_ready && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      we_q <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
    end else if (!v_q) begin
      if (q_pop) begin
        v_q  <= 1'b1;
        we_q <= 1'b1;
        a_q  <= q_head.addr;
        d_q  <= q_head.data;
      end else if (rd_take) begin
        v_q  <= 1'b1;
        we_q <= 1'b0;
        a_q  <= rd_addr;
        d_q  <= '0;
      end
    end else if (dn_ready) begin
      v_q <= 1'b0;
    end
  end

  assign dn_valid = v_q;
  assign dn_we    = we_q;
  assign dn_addr  = a_q;
  assign dn_wdata = d_q;
endmodule

// File: rtl/pmic_bridge_chan.sv
module pmic_bridge_chan
  import pmic_bridge_pkg::*;
#(
  parameter int N_CHAN = 50,
  parameter int N_SW   = 2,
  parameter int CFG_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HOST_AW-1:0] wr_addr,
  input  logic [HOST_DW-1:0] wr_data,
  input  logic [HOST_AW-1:0] rd_addr,
  output logic               rd_hit,
  output logic [HOST_DW-1:0] rd_data,
  output logic [N_CHAN-1:0]  chan_en
);
  localparam int N_HW  = N_CHAN - N_SW;
  localparam int HI_N  = N_CHAN - 32;
  localparam int IDX_W = $clog2(N_HW);
  localparam logic [HOST_AW-1:0] CFG_END = A_CFG_BASE + HOST_AW'(4 * N_HW);

  logic [N_CHAN-1:0] en_q, en_d;
  logic [CFG_W-1:0]  cfg_w [N_HW];

  always_comb begin
    en_d = en_q;
    if (wr_en && wr_addr == A_EN_LO) en_d[31:0] = wr_data;
    if (wr_en && wr_addr == A_EN_HI) en_d[N_CHAN-1:32] = wr_data[HI_N-1:0];
    en_d[N_SW-1:0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar g = 0; g < N_HW; g++) begin : g_cfg
    localparam logic [HOST_AW-1:0] MY_ADDR = A_CFG_BASE + HOST_AW'(4 * g);
    logic [CFG_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q <= '0;
      else if (wr_en && wr_addr == MY_ADDR) word_q <= wr_data[CFG_W-1:0];
    end
    assign cfg_w[g] = word_q;
  end

  logic [HOST_AW-1:0] cfg_ofs;
  logic [IDX_W-1:0]   cfg_idx;
  logic               cfg_hit;

  assign cfg_ofs = rd_addr - A_CFG_BASE;
  assign cfg_idx = cfg_ofs[IDX_W+1:2];
  assign cfg_hit = (rd_addr >= A_CFG_BASE) && (rd_addr < CFG_END) && (rd_addr[1:0] == 2'b00);

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    if (rd_addr == A_EN_LO)      rd_data = en_q[31:0];
    else if (rd_addr == A_EN_HI) rd_data = HOST_DW'(en_q[N_CHAN-1:32]);
    else if (cfg_hit)            rd_data = HOST_DW'(cfg_w[cfg_idx]);
    else                         rd_hit  = 1'b0;
  end

  assign chan_en = en_q;
endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int N_CHAN     = 50,
  parameter int N_SW       = 2,
  parameter int CFG_W      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [15:0]        host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic               dn_we,
  output logic [11:0]        dn_addr,
  output logic [15:0]        dn_wdata,
  input  logic [15:0]        dn_rdata,
  output logic [N_CHAN-1:0]  chan_en
);
  logic host_wr, win_hit, win_wr, cmd_wr, ovf_clr;
  assign host_wr = host_sel && host_we;
  assign win_hit = (host_addr[15:12] == WIN_NIBBLE);
  assign win_wr  = host_wr && win_hit;
  assign ovf_clr = host_wr && (host_addr == A_Q_STAT) && host_wdata[ST_OVF];

  // write queue
  wr_ent_t q_din, q_head;
  logic    q_push, q_pop, q_full, q_empty;
  assign q_din.addr = host_addr[SLV_AW-1:0];
  assign q_din.data = host_wdata[SLV_DW-1:0];
  assign q_push     = win_wr && !q_full;

  pmic_bridge_wq #(.DEPTH(FIFO_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din),
    .pop(q_pop), .dout(q_head), .full(q_full), .empty(q_empty)
  );

  // read command state
  logic              rd_busy_q, rd_pend_q, rd_take, rd_done;
  logic [SLV_AW-1:0] rd_addr_q, rd_echo_q;
  logic [SLV_DW-1:0] rd_data_q;
  assign cmd_wr = host_wr && (host_addr == A_RD_CMD) && !rd_busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy_q <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      rd_echo_q <= '0;
      rd_data_q <= '0;
    end else begin
      if (cmd_wr) begin
        rd_busy_q <= 1'b1;
        rd_pend_q <= 1'b1;
        rd_addr_q <= host_wdata[SLV_AW-1:0];
      end
      if (rd_take) rd_pend_q <= 1'b0;
      if (rd_done) begin
        rd_busy_q <= 1'b0;
        rd_data_q <= dn_rdata;
        rd_echo_q <= rd_addr_q;
      end
    end
  end

  // sticky overflow
  logic ovf_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovf_q <= 1'b0;
    else if (win_wr && q_full)   ovf_q <= 1'b1;
    else if (ovf_clr)            ovf_q <= 1'b0;
  end

  pmic_bridge_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .rd_pend(rd_pend_q), .rd_addr(rd_addr_q),
    .rd_take(rd_take), .rd_done(rd_done),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_we(dn_we),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata)
  );

  logic              ch_hit;
  logic [HOST_DW-1:0] ch_rdata;
  pmic_bridge_chan #(.N_CHAN(N_CHAN), .N_SW(N_SW), .CFG_W(CFG_W)) u_chan (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr), .wr_addr(host_addr), .wr_data(host_wdata),
    .rd_addr(host_addr), .rd_hit(ch_hit), .rd_data(ch_rdata),
    .chan_en(chan_en)
  );

  // status and read mux
  logic               wq_idle;
  logic [HOST_DW-1:0] stat_w, res_w;
  assign wq_idle = q_empty && !(dn_valid && dn_we);

  always_comb begin
    stat_w           = '0;
    stat_w[ST_EMPTY] = wq_idle;
    stat_w[ST_FULL]  = q_full;
    stat_w[ST_OVF]   = ovf_q;
  end

  assign res_w = {rd_busy_q, 3'b000, rd_echo_q, rd_data_q};

  always_comb begin
    host_rdata = '0;
    if (host_sel && !host_we) begin
      if (host_addr == A_RD_RES)      host_rdata = res_w;
      else if (host_addr == A_Q_STAT) host_rdata = stat_w;
      else if (ch_hit)                host_rdata = ch_rdata;
    end
  end
endmodule

// File: rtl/pmic_bridge_chk.sv
module pmic_bridge_chk
  import pmic_bridge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_we,
  input logic [15:0]       host_addr,
  input logic [31:0]       host_wdata,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              dn_we,
  input logic [11:0]       dn_addr,
  input logic [15:0]       dn_wdata,
  input logic              q_empty,
  input logic              q_full,
  input logic              wq_idle,
  input logic              rd_busy,
  input logic [11:0]       rd_addr,
  input logic              ovf
);
  logic cmd_any, stat_clr;
  assign cmd_any  = host_sel && host_we && (host_addr == A_RD_CMD);
  assign stat_clr = host_sel && host_we && (host_addr == A_Q_STAT) && host_wdata[ST_OVF];

  // R3
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_we) && $stable(dn_addr) && $stable(dn_wdata));

  // R7
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_valid) && !dn_we |-> $past(q_empty));

  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any |=> rd_busy);

  // R6
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_busy) |-> $past(dn_valid && dn_ready && !dn_we));

  // R8
  cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any && rd_busy |=> $stable(rd_addr));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !stat_clr |=> ovf);

  // R4
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && wq_idle));
endmodule

bind pmic_bridge pmic_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
  .q_empty(q_empty), .q_full(q_full), .wq_idle(wq_idle),
  .rd_busy(rd_busy_q), .rd_addr(rd_addr_q), .ovf(ovf_q)
);

// File: tb/pmic_bridge_tb_top.sv
module pmic_bridge_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        dn_valid, dn_ready, dn_we;
  logic [11:0] dn_addr;
  logic [15:0] dn_wdata, dn_rdata;
  logic [49:0] chan_en;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pmic_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_we(dn_we), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .chan_en(chan_en)
  );

  // slave model
  logic [15:0] smem [4096];
  logic [11:0] log_a [64];
  logic [15:0] log_d [64];
  int          log_n = 0;
  bit          stall = 0;
  int          lat = 0, wcnt = 0;

  initial for (int i = 0; i < 4096; i++) smem[i] = '0;

  assign dn_ready = dn_valid && !stall && (wcnt >= lat);
  assign dn_rdata = smem[dn_addr];

  always @(posedge clk) begin
    if (dn_valid && dn_ready) begin
      wcnt = 0;
      if (dn_we) begin
        smem[dn_addr] = dn_wdata;
        if (log_n < 64) begin
          log_a[log_n] = dn_addr;
          log_d[log_n] = dn_wdata;
        end
        log_n++;
      end
    end else if (dn_valid) begin
      wcnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #1 d = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      hrd(16'h0030, s);
      if (s[10]) break;
    end
  endtask

  task automatic wait_result(output logic [31:0] r);
    for (int i = 0; i < 500; i++) begin
      hrd(16'h002c, r);
      if (!r[31]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] r;
    hrd(16'h0030, r); check("R1 status", r, 32'h0000_0400);
    hrd(16'h002c, r); check("R1 result", r, 32'h0);
    check("R1 dn_valid", {31'b0, dn_valid}, 32'h0);
    check("R1 chan_en", {14'b0, chan_en[49:32]} | chan_en[31:0], 32'h0);
  endtask

  task automatic t_post();
    int base;
    base = log_n;
    lat = 2;
    hwr(16'h7ffe, 32'h1111);   // R11 below window
    hwr(16'h9000, 32'h2222);   // R11 above window
    hwr(16'h8010, 32'hffff_1234);
    hwr(16'h8ffe, 32'h0000_beef);
    hwr(16'h8000, 32'h0000_0001);
    wait_idle();
    check("R11 count", log_n - base, 3);
    check("R2 a0", {20'b0, log_a[base]},   32'h010);
    check("R2 d0", {16'b0, log_d[base]},   32'h1234);
    check("R2 a1", {20'b0, log_a[base+1]}, 32'hffe);
    check("R2 d1", {16'b0, log_d[base+1]}, 32'hbeef);
    check("R2 a2", {20'b0, log_a[base+2]}, 32'h000);
  endtask

  task automatic t_fill();
    logic [31:0] r;
    int base;
    base = log_n;
    lat = 0;
    stall = 1;
    for (int i = 0; i < 9; i++) hwr(16'h8100 + 16'(i), 32'h0000_a000 + i);
    @(negedge clk);
    check("R3 held valid", {31'b0, dn_valid}, 32'h1);
    check("R3 held addr", {20'b0, dn_addr}, 32'h100);
    check("R3 held data", {16'b0, dn_wdata}, 32'ha000);
    hrd(16'h0030, r); check("R4 full after 9", r, 32'h0000_0800);
    hwr(16'h8200, 32'h0000_dead);
    hrd(16'h0030, r); check("R5 overflow set", r, 32'h0000_1800);
    stall = 0;
    wait_idle();
    check("R5 dropped count", log_n - base, 9);
    check("R4 last kept", {16'b0, log_d[base+8]}, 32'ha008);
    hrd(16'h0030, r); check("R5 sticky", r, 32'h0000_1400);
    hwr(16'h0030, 32'h0000_1000);
    hrd(16'h0030, r); check("R5 cleared", r, 32'h0000_0400);
  endtask

  task automatic t_read();
    logic [31:0] r;
    lat = 3;
    stall = 1;
    hwr(16'h8040, 32'h0000_5a5a);
    hwr(16'h0028, 32'h0000_8040);
    hrd(16'h002c, r); check("R6 busy", {31'b0, r[31]}, 32'h1);
    hwr(16'h0028, 32'h0000_0123);   // ignored while busy
    stall = 0;
    wait_result(r);
    check("R7 data after posted write", r, 32'h0040_5a5a);
    check("R8 echo unchanged", {20'b0, r[27:16]}, 32'h040);
    hwr(16'h0028, 32'h0000_8ffe);
    wait_result(r);
    check("R6 result", r, 32'h0ffe_beef);
  endtask

  task automatic t_chan();
    logic [31:0] r;
    int base;
    base = log_n;
    hwr(16'h0040, 32'hffff_ffff);
    hrd(16'h0040, r); check("R9 low reg", r, 32'hffff_fffc);
    check("R9 chan_en low", chan_en[31:0], 32'hffff_fffc);
    hwr(16'h020c, 32'hffff_ffff);
    hrd(16'h020c, r); check("R9 high reg", r, 32'h0003_ffff);
    check("R9 chan_en high", {14'b0, chan_en[49:32]}, 32'h0003_ffff);
    hwr(16'h0040, 32'h0000_0005);
    check("R9 bit pattern", chan_en[31:0], 32'h0000_0004);
    hwr(16'h0044, 32'h1111_2222);
    hwr(16'h0100, 32'hdead_beef);
    hwr(16'h0070, 32'h0bad_f00d);
    hrd(16'h0044, r); check("R10 ch2", r, 32'h1111_2222);
    hrd(16'h0100, r); check("R10 ch49", r, 32'hdead_beef);
    hrd(16'h0070, r); check("R10 ch13", r, 32'h0bad_f00d);
    repeat (4) @(negedge clk);
    check("R11 no downstream", log_n - base, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_post();
    t_fill();
    t_read();
    t_chan();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule